// File: doc/BRIEF.md
# Burner Phase Sequencing Controller

This block runs a heating appliance through its firing cycle. Four phases follow each other in a fixed loop: idle, purge, ignite, burn, and then idle again. The block has one output that opens the gas valve. A heat-demand input starts a cycle. A flame-present input keeps the burn phase going. A one-cycle strobe, once per second, is the time base for the dwell phases.

The demand and flame inputs come from outside the clock domain. Each passes through a short synchronizer chain before the sequencer uses it. The time spent in purge and in ignite is measured by one shared down-counter. The counter is loaded as the phase is entered and decremented on each strobe. The phase moves on once the counter is zero. The current phase is shown on a 2-bit code so that other logic can observe the sequence.

Top module: `burner_seq_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the block in idle (code 00) with the valve closed (0) and clears the dwell counter. A purge entered after reset therefore always lasts the full purge dwell.
- R2: The phase code is idle=00, purge=01, ignite=10, burn=11. Every phase change moves to the next code modulo 4, so burn goes back to idle.
- R3: In idle, a demand that is high moves the block to purge. The phase code changes on the (SYNC_STAGES+1)-th rising clock edge after the input goes high. With the default of 2 stages this is the 3rd edge.
- R4: In idle with demand low, the block stays in idle. The time strobe and the flame input have no effect.
- R5: Purge keeps the valve closed. It lasts exactly PURGE_TICKS strobes (default 30), counted from entry. The phase code changes to ignite one clock after the last of those strobes.
- R6: Losing demand during purge does not shorten the purge or end it.
- R7: Ignite opens the valve. It lasts IGNITE_TICKS strobes (default 1) and then goes to burn, whatever the flame input shows.
- R8: Burn keeps the valve open. It stays in burn as long as demand and flame are both high.
- R9: In burn, losing the flame or losing demand returns the block to idle. If demand is still high, a fresh purge of the full length follows.
- R10: The valve output is 1 in ignite and burn and 0 in idle and purge, on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| heat_req | input | 1 | Heat demand, asynchronous |
| flame_ok | input | 1 | Flame present, asynchronous |
| sec_tick | input | 1 | One-clock strobe, once per second, synchronous |
| valve_on | output | 1 | Gas valve open command |
| phase | output | 2 | Current phase: 00 idle, 01 purge, 10 ignite, 11 burn |

## Verification
The stimulus table takes the block through a full cycle several times, each ending in a different way.
- Losing the flame with demand still high tells a return to idle followed by a reloaded purge apart from a purge that resumes with a leftover count.
- Losing demand separates the demand exit from the flame exit.
- Dropping demand part-way through purge shows that the purge dwell is never cut short.
- Strobe counts one short of the dwell, and exactly equal to it, separate an off-by-one counter from a correct one.

Directed tests then measure the synchronizer latency edge by edge. They also apply reset in the middle of a purge and confirm that the next purge lasts the full length.

// File: rtl/burner_pkg.sv
package burner_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'b00,
    PH_PURGE  = 2'b01,
    PH_IGNITE = 2'b10,
    PH_BURN   = 2'b11
  } phase_e;

  // Width needed to hold a tick count in 0..max_ticks
  function automatic int tick_width(input int max_ticks);
    int w;
    w = 1;
    while ((1 << w) <= max_ticks) w++;
    return w;
  endfunction

  // Valve command belonging to a phase
  function automatic logic valve_for(input phase_e ph);
    return (ph == PH_IGNITE) || (ph == PH_BURN);
  endfunction

  // Successor of a phase in the fixed loop
  function automatic phase_e next_in_loop(input phase_e ph);
    return phase_e'(ph + 2'd1);
  endfunction

endpackage

// File: rtl/burner_sync.sv
module burner_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/burner_dwell.sv
module burner_dwell #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                       cnt_q <= '0;
    else if (load)                 cnt_q <= load_val;
    else if (tick && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt  = cnt_q;
  assign done = (cnt_q == '0);

endmodule

// File: rtl/burner_phase_fsm.sv
module burner_phase_fsm
  import burner_pkg::*;
#(
  parameter int CNT_W        = 5,
  parameter int PURGE_TICKS  = 30,
  parameter int IGNITE_TICKS = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             heat_s,
  input  logic             flame_s,
  input  logic             dwell_done,
  output phase_e           phase,
  output logic             valve_on,
  output logic             load,
  output logic [CNT_W-1:0] load_val
);

  phase_e phase_q, phase_d;
  logic   valve_q;

  always_comb begin
    phase_d  = phase_q;
    load     = 1'b0;
    load_val = '0;
    unique case (phase_q)
      PH_IDLE: begin
        if (heat_s) begin
          phase_d  = next_in_loop(phase_q);
          load     = 1'b1;
          load_val = CNT_W'(PURGE_TICKS);
        end
      end
      PH_PURGE: begin
        if (dwell_done) begin
          phase_d  = next_in_loop(phase_q);
          load     = 1'b1;
          load_val = CNT_W'(IGNITE_TICKS);
        end
      end
      PH_IGNITE: begin
        if (dwell_done) phase_d = next_in_loop(phase_q);
      end
      PH_BURN: begin
        if (!heat_s || !flame_s) phase_d = next_in_loop(phase_q);
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      valve_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      valve_q <= valve_for(phase_d);
    end
  end

  assign phase    = phase_q;
  assign valve_on = valve_q;

endmodule

// File: rtl/burner_seq_ctrl.sv
module burner_seq_ctrl
  import burner_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int PURGE_TICKS  = 30,
  parameter int IGNITE_TICKS = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       heat_req,
  input  logic       flame_ok,
  input  logic       sec_tick,
  output logic       valve_on,
  output logic [1:0] phase
);

  localparam int MAX_TICKS = (PURGE_TICKS > IGNITE_TICKS) ? PURGE_TICKS : IGNITE_TICKS;
  localparam int CNT_W     = tick_width(MAX_TICKS);

  // Named internal events for the checker
  logic             heat_s;
  logic             flame_s;
  logic             dwell_done;
  logic             dwell_load;
  logic [CNT_W-1:0] dwell_val;
  logic [CNT_W-1:0] dwell_cnt;
  logic [1:0]       synced;
  phase_e           phase_st;

  burner_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({flame_ok, heat_req}),
    .dout (synced)
  );
  assign heat_s  = synced[0];
  assign flame_s = synced[1];

  burner_dwell #(.CNT_W(CNT_W)) u_dwell (
    .clk      (clk),
    .rst      (rst),
    .load     (dwell_load),
    .load_val (dwell_val),
    .tick     (sec_tick),
    .cnt      (dwell_cnt),
    .done     (dwell_done)
  );

  burner_phase_fsm #(
    .CNT_W        (CNT_W),
    .PURGE_TICKS  (PURGE_TICKS),
    .IGNITE_TICKS (IGNITE_TICKS)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .heat_s     (heat_s),
    .flame_s    (flame_s),
    .dwell_done (dwell_done),
    .phase      (phase_st),
    .valve_on   (valve_on),
    .load       (dwell_load),
    .load_val   (dwell_val)
  );

  assign phase = phase_st;

endmodule

// File: rtl/burner_seq_checks.sv
module burner_seq_checks #(
  parameter int CNT_W     = 5,
  parameter int MAX_TICKS = 30
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       phase,
  input logic             valve_on,
  input logic             heat_s,
  input logic             flame_s,
  input logic             dwell_done,
  input logic [CNT_W-1:0] dwell_cnt
);

  p_loop_order_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && phase != $past(phase)) |-> (phase == $past(phase) + 2'd1));

  p_idle_to_purge_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'b00 && heat_s) |=> (phase == 2'b01));

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'b00 && !heat_s) |=> (phase == 2'b00));

  p_purge_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'b01 && !dwell_done) |=> (phase == 2'b01));

  p_ignite_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'b10 && !dwell_done) |=> (phase == 2'b10));

  p_burn_stay_r8: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'b11 && heat_s && flame_s) |=> (phase == 2'b11));

  p_burn_exit_r9: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'b11 && !(heat_s && flame_s)) |=> (phase == 2'b00));

  p_valve_phase_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (valve_on == phase[1]));

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (dwell_cnt <= CNT_W'(MAX_TICKS)));

endmodule

bind burner_seq_ctrl burner_seq_checks #(
  .CNT_W     (CNT_W),
  .MAX_TICKS (MAX_TICKS)
) u_checks (
  .clk        (clk),
  .rst        (rst),
  .phase      (phase),
  .valve_on   (valve_on),
  .heat_s     (heat_s),
  .flame_s    (flame_s),
  .dwell_done (dwell_done),
  .dwell_cnt  (dwell_cnt)
);

// File: tb/burner_seq_ctrl_test.sv
module burner_seq_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 14;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       heat_req = 1'b0;
  logic       flame_ok = 1'b0;
  logic       sec_tick = 1'b0;
  logic       valve_on;
  logic [1:0] phase;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burner_seq_ctrl uut (
    .clk      (clk),
    .rst      (rst),
    .heat_req (heat_req),
    .flame_ok (flame_ok),
    .sec_tick (sec_tick),
    .valve_on (valve_on),
    .phase    (phase)
  );

  // {heat, flame, ticks[5:0], phase[1:0], valve}
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 6'd0,  2'd0, 1'b0},  // R4 idle holds without demand
    {1'b1, 1'b0, 6'd0,  2'd1, 1'b0},  // R3 demand -> purge
    {1'b1, 1'b0, 6'd29, 2'd1, 1'b0},  // R5 one strobe short
    {1'b1, 1'b0, 6'd1,  2'd2, 1'b1},  // R5 R7 ignite, valve open
    {1'b1, 1'b1, 6'd1,  2'd3, 1'b1},  // R7 -> burn
    {1'b1, 1'b1, 6'd5,  2'd3, 1'b1},  // R8 burn stable
    {1'b1, 1'b0, 6'd0,  2'd1, 1'b0},  // R9 flame loss -> idle -> new purge
    {1'b1, 1'b0, 6'd30, 2'd2, 1'b1},  // R9 full reloaded purge
    {1'b1, 1'b1, 6'd1,  2'd3, 1'b1},  // R8 burn again
    {1'b0, 1'b1, 6'd0,  2'd0, 1'b0},  // R9 demand loss -> idle
    {1'b0, 1'b1, 6'd10, 2'd0, 1'b0},  // R4 strobes ignored in idle
    {1'b1, 1'b1, 6'd0,  2'd1, 1'b0},  // R3 new cycle
    {1'b0, 1'b1, 6'd30, 2'd2, 1'b1},  // R6 purge runs despite demand loss
    {1'b0, 1'b1, 6'd1,  2'd0, 1'b0}   // R2 burn passes straight to idle
  };

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {phase,valve} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic pulse_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sec_tick = 1'b1;
      @(negedge clk) sec_tick = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset state", {phase, valve_on}, 3'b000);
    rst = 1'b0;

    // Table-driven sequence
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      heat_req = VEC[v][10];
      flame_ok = VEC[v][9];
      repeat (3) @(negedge clk);
      pulse_ticks(int'(VEC[v][8:3]));
      repeat (4) @(negedge clk);
      check($sformatf("R2 vector %0d", v), {phase, valve_on}, VEC[v][2:0]);
    end

    // R3 latency, edge by edge (block is idle, demand low)
    @(negedge clk) heat_req = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R3 still idle after 2 edges", {phase, valve_on}, 3'b000);
    @(posedge clk); #1;
    check("R3 purge on 3rd edge", {phase, valve_on}, 3'b010);

    // R1 reset in mid-purge clears the counter
    pulse_ticks(20);
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid-purge", {phase, valve_on}, 3'b000);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    pulse_ticks(29);
    repeat (2) @(negedge clk);
    check("R1 R5 full purge after reset", {phase, valve_on}, 3'b010);
    pulse_ticks(1);
    check("R5 ignite after full dwell", {phase, valve_on}, 3'b101);

    // R9 flame loss from burn: idle exactly on 3rd edge
    @(negedge clk) flame_ok = 1'b1;
    repeat (3) @(negedge clk);
    pulse_ticks(1);
    check("R8 burn reached", {phase, valve_on}, 3'b111);
    @(negedge clk) flame_ok = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    check("R9 burn before sync delay", {phase, valve_on}, 3'b111);
    @(posedge clk); #1;
    check("R9 R10 idle and valve closed", {phase, valve_on}, 3'b000);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule